// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block is a hardware master that loads a configuration bitstream into a downstream FPGA over that device's slave-serial pins. A start request begins a session. The block drives the active-low program line low for a fixed number of cycles, releases it, and confirms that the target's DONE line is low. It then waits out the target's internal clear time. After that wait it pulls bitstream bytes from a valid/ready stream and shifts each byte out MSB first, one serial clock per bit.

Once the byte flagged as last has been shifted out, the block keeps sending all-ones bytes until DONE is seen high, and then sends one further all-ones byte. If DONE stays low for a parameterised number of all-ones bytes, it stops and reports a timeout. A request for partial reconfiguration is refused at once and leaves the program line untouched. The DONE input passes through a two-flop synchroniser. Status (busy, success, 2-bit error code) holds until the next accepted start.

Top module: `fpga_serial_loader`

## Requirements
- R1: While idle, a start with `partial`=0 raises `busy` and holds `prog_n` low for exactly PULSE_CYC clock cycles.
- R2: If DONE is already high just after `prog_n` is released, the session ends with `err`=1 and `done_ok`=0, and no serial clock edge is produced.
- R3: The first rising edge of `sclk` comes at least CLEAR_CYC clock cycles after `prog_n` returns high.
- R4: Each accepted byte goes out MSB first, one bit per `sclk` period of CLK_DIV cycles. `sdata` is stable while `sclk` is high. `sclk` stays low while `s_ready` waits for a byte, so stream gaps produce no edges.
- R5: If DONE is high by the end of the last bitstream byte, exactly 8 further `sclk` edges follow with `sdata`=1, then `done_ok`=1 and `err`=0.
- R6: If DONE rises partway through the k-th trailing all-ones byte, the block sends 8*(k+1) trailing edges in total, all with `sdata`=1, then reports `done_ok`=1.
- R7: If DONE stays low, the block sends exactly 8*TIMEOUT_BYTES trailing all-ones edges and then ends with `err`=2 and `done_ok`=0.
- R8: A start with `partial`=1 sets `err`=3, leaves `prog_n` high and `busy` low, and produces no serial clocks.
- R9: `done_ok` and `err` hold their values until the next accepted start, which clears them. A start seen while `busy` is high is ignored.
- R10: After reset, `prog_n`=1, `sclk`=0, `busy`=0, `s_ready`=0, `done_ok`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Session request (acted on when idle) |
| partial | input | 1 | Marks the request as partial reconfiguration |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Byte valid |
| s_last | input | 1 | Byte is the final bitstream byte |
| s_ready | output | 1 | Block accepts a byte |
| prog_n | output | 1 | Active-low program line to the target |
| sclk | output | 1 | Serial configuration clock |
| sdata | output | 1 | Serial configuration data |
| done_in | input | 1 | Target DONE line, asynchronous |
| busy | output | 1 | Session in progress |
| done_ok | output | 1 | Last session finished successfully |
| err | output | 2 | Error code: 0 none, 1 DONE high early, 2 timeout, 3 unsupported |

## Verification
The bench builds the block with CLK_DIV=4, PULSE_CYC=8, CLEAR_CYC=20 and TIMEOUT_BYTES=3. At these values a full session lasts a few hundred cycles, so random sessions can reach every ending. The short timeout means a DONE rise in the first, second or third trailing byte, and the timeout case itself, all fall within one session. The two-cycle serial half period still leaves room for the synchroniser latency when DONE rises mid-byte.

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader #(
  parameter int CLK_DIV       = 4,
  parameter int PULSE_CYC     = 100,
  parameter int CLEAR_CYC     = 750000,
  parameter int TIMEOUT_BYTES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       partial,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       prog_n,
  output logic       sclk,
  output logic       sdata,
  input  logic       done_in,
  output logic       busy,
  output logic       done_ok,
  output logic [1:0] err
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int CNT_W = $clog2(PULSE_CYC + CLEAR_CYC + 1);
  localparam int TO_W  = $clog2(TIMEOUT_BYTES + 1);

  localparam logic [1:0] E_NONE = 2'd0, E_EARLY = 2'd1, E_TIME = 2'd2, E_UNSUP = 2'd3;
  localparam logic [1:0] K_DATA = 2'd0, K_POLL = 2'd1, K_FINAL = 2'd2;

  typedef enum logic [2:0] {IDLE, PULSE, CLEAR, FETCH, SHIFT, POLL} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitn;
  logic [7:0]       shreg;
  logic [1:0]       kind;
  logic             last_q;
  logic [TO_W-1:0]  ffcnt;
  logic [1:0]       sync;
  logic             done_s;

  assign done_s  = sync[1];
  assign busy    = (st != IDLE);
  assign prog_n  = (st != PULSE);
  assign s_ready = (st == FETCH);
  assign sclk    = (st == SHIFT) && (div >= DIV_W'(HALF));
  assign sdata   = (st == SHIFT) ? shreg[7] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], done_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      div     <= '0;
      bitn    <= '0;
      shreg   <= 8'hFF;
      kind    <= K_DATA;
      last_q  <= 1'b0;
      ffcnt   <= '0;
      done_ok <= 1'b0;
      err     <= E_NONE;
    end else begin
      case (st)
        IDLE: if (start) begin
          done_ok <= 1'b0;
          if (partial) err <= E_UNSUP;
          else begin
            err <= E_NONE;
            cnt <= '0;
            st  <= PULSE;
          end
        end
        PULSE: begin
          if (cnt == CNT_W'(PULSE_CYC - 1)) begin
            cnt <= '0;
            st  <= CLEAR;
          end else cnt <= cnt + 1'b1;
        end
        CLEAR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(2) && done_s) begin
            err <= E_EARLY;
            st  <= IDLE;
          end else if (cnt == CNT_W'(CLEAR_CYC - 1)) st <= FETCH;
        end
        FETCH: if (s_valid) begin
          shreg  <= s_data;
          last_q <= s_last;
          kind   <= K_DATA;
          bitn   <= '0;
          div    <= '0;
          st     <= SHIFT;
        end
        SHIFT: begin
          if (div == DIV_W'(CLK_DIV - 1)) begin
            div <= '0;
            if (bitn == 3'd7) begin
              case (kind)
                K_DATA: begin
                  ffcnt <= '0;
                  st    <= last_q ? POLL : FETCH;
                end
                K_POLL: begin
                  ffcnt <= ffcnt + 1'b1;
                  st    <= POLL;
                end
                default: begin
                  done_ok <= 1'b1;
                  st      <= IDLE;
                end
              endcase
            end else begin
              shreg <= {shreg[6:0], 1'b1};
              bitn  <= bitn + 1'b1;
            end
          end else div <= div + 1'b1;
        end
        POLL: begin
          if (!done_s && ffcnt == TO_W'(TIMEOUT_BYTES)) begin
            err <= E_TIME;
            st  <= IDLE;
          end else begin
            shreg <= 8'hFF;
            kind  <= done_s ? K_FINAL : K_POLL;
            bitn  <= '0;
            div   <= '0;
            st    <= SHIFT;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpga_serial_loader_chk.sv
module fpga_serial_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       s_ready,
  input logic       prog_n,
  input logic       sclk,
  input logic       busy,
  input logic       done_ok,
  input logic [1:0] err
);
  a_r1_prog_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> busy);
  a_r1_no_clock_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !sclk);
  a_r4_no_clock_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!sclk && prog_n));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !s_ready));
  a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err) && $stable(done_ok)));
  a_r5_ok_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (err == 2'd0));
endmodule

bind fpga_serial_loader fpga_serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .s_ready(s_ready), .prog_n(prog_n),
  .sclk(sclk), .busy(busy), .done_ok(done_ok), .err(err)
);

// File: tb/fpga_serial_loader_test.sv
module fpga_serial_loader_test;
  localparam int CLK_DIV = 4, PULSE_CYC = 8, CLEAR_CYC = 20, TO_BYTES = 3;

  logic clk = 0, rst_n = 0;
  logic start = 0, partial = 0, s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, prog_n, sclk, sdata, busy, done_ok;
  logic [1:0] err;
  logic done_force = 0, done_tgt = 0;
  wire  done_in = done_force | done_tgt;

  int checks = 0, fails = 0;
  int raise_at = -1;
  int edges, plow, busy_cyc, t, t_rel, t_first, hold_bad, rdy_bad;
  bit bits [0:255];
  logic prev_sclk, prev_prog, rise_val;
  logic [7:0] exp_b [0:15];

  always #4 clk = ~clk;

  fpga_serial_loader #(.CLK_DIV(CLK_DIV), .PULSE_CYC(PULSE_CYC),
    .CLEAR_CYC(CLEAR_CYC), .TIMEOUT_BYTES(TO_BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .s_data(s_data),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready), .prog_n(prog_n),
    .sclk(sclk), .sdata(sdata), .done_in(done_in), .busy(busy),
    .done_ok(done_ok), .err(err));

  always @(posedge clk) begin
    t <= t + 1;
    prev_sclk <= sclk;
    prev_prog <= prog_n;
    if (start && !busy) begin
      edges <= 0; plow <= 0; busy_cyc <= 0; t_rel <= 0; t_first <= -1;
      hold_bad <= 0; rdy_bad <= 0; done_tgt <= 0;
    end else begin
      if (!prog_n) plow <= plow + 1;
      if (busy) busy_cyc <= busy_cyc + 1;
      if (prog_n && !prev_prog) t_rel <= t;
      if (s_ready && sclk) rdy_bad <= rdy_bad + 1;
      if (sclk && !prev_sclk) begin
        if (edges < 256) bits[edges] <= sdata;
        rise_val <= sdata;
        if (t_first < 0) t_first <= t;
        if (raise_at >= 0 && edges + 1 == raise_at) done_tgt <= 1;
        edges <= edges + 1;
      end else if (sclk && sdata !== rise_val) hold_bad <= hold_bad + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_extra(int k);
    return (k < 0) ? 8 * TO_BYTES : 8 * k + 8;
  endfunction

  task automatic session(int nb, int k, bit part, bit early, bit restart);
    raise_at = (k < 0) ? -1 : (k == 0 ? 4 : 8 * nb + 8 * k - 4);
    done_force = early;
    for (int i = 0; i < nb; i++) exp_b[i] = 8'($urandom);
    @(negedge clk); start = 1; partial = part;
    @(negedge clk); start = 0; partial = 0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    if (!part && !early) begin
      for (int i = 0; i < nb; i++) begin
        repeat ($urandom % 3) @(negedge clk);
        s_valid = 1; s_data = exp_b[i]; s_last = (i == nb - 1);
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 0; s_last = 0;
      end
    end
    while (busy) @(negedge clk);
    done_force = 0;
    if (part) begin
      chk(err == 2'd3, "R8 err", err, 3);
      chk(plow == 0 && busy_cyc == 0, "R8 prog/busy", plow + busy_cyc, 0);
      chk(edges == 0, "R8 clocks", edges, 0);
    end else if (early) begin
      chk(plow == PULSE_CYC, "R1 pulse", plow, PULSE_CYC);
      chk(err == 2'd1 && !done_ok, "R2 err", err, 1);
      chk(edges == 0, "R2 clocks", edges, 0);
    end else begin
      bit dok = 1, tok = 1;
      chk(plow == PULSE_CYC, "R1 pulse", plow, PULSE_CYC);
      chk(t_first - t_rel >= CLEAR_CYC, "R3 clear wait", t_first - t_rel, CLEAR_CYC);
      for (int i = 0; i < 8 * nb; i++)
        if (bits[i] != exp_b[i / 8][7 - (i % 8)]) dok = 0;
      chk(dok, "R4 data bits", dok, 1);
      chk(hold_bad == 0 && rdy_bad == 0, "R4 sdata/sclk timing", hold_bad + rdy_bad, 0);
      chk(edges - 8 * nb == exp_extra(k),
          (k < 0) ? "R7 trailing edges" : (k == 0 ? "R5 trailing edges" : "R6 trailing edges"),
          edges - 8 * nb, exp_extra(k));
      for (int i = 8 * nb; i < edges && i < 256; i++) if (!bits[i]) tok = 0;
      chk(tok, "R5 trailing ones", tok, 1);
      if (k < 0) chk(err == 2'd2 && !done_ok, "R7 timeout status", err, 2);
      else       chk(err == 2'd0 && done_ok, "R6 success status", done_ok, 1);
    end
    begin
      logic [1:0] e0 = err; logic d0 = done_ok;
      repeat (10) @(negedge clk);
      chk(err == e0 && done_ok == d0, "R9 status holds", err, e0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    t = 0;
    repeat (3) @(negedge clk);
    chk(prog_n && !sclk && !busy && !s_ready && !done_ok && err == 0,
        "R10 reset state", {prog_n, sclk, busy, s_ready}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    session(2, 0, 0, 0, 0);
    session(1, 1, 0, 0, 0);
    session(3, -1, 0, 0, 0);
    session(2, 0, 0, 1, 0);
    session(1, 0, 1, 0, 0);
    chk(!busy && err == 2'd3, "R9 start cleared previous", err, 3);
    session(2, 2, 0, 0, 1);
    session(3, 3, 0, 0, 0);
    for (int n = 0; n < 12; n++)
      session(1 + $urandom % 5, int'($urandom % 5) - 1, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule